// File: doc/BRIEF.md
# Banked CPU Register File

This block is the architectural register storage of a small processor core. It keeps two complete sets of general registers. Each set holds four 16-bit data registers, two 24-bit address registers and a 24-bit frame base. Both sets share a 24-bit static base, a 24-bit interrupt table base and two 24-bit stack pointers, one for user code and one for interrupt code. A bank-select pin chooses which set is visible. A stack-select pin chooses which stack pointer answers to the stack-pointer code. Both pins are normally driven from the core's flag register.

The data registers can be reached in three sizes. The first two data registers split into independent low and high bytes. Any data register can be accessed as a 16-bit word. Two fixed pairs combine into 32-bit operands. The operand size follows from the register code. Two combinational read ports and one clocked write port serve the decode and execute stages. A status output warns when the active stack pointer holds an odd address. Every pin is a plain control or data pin, sampled on each rising clock edge. The block has no handshake, so it never stalls its neighbours.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous active-high reset clears every data, address, frame base, static base, stack pointer and interrupt table register in both banks. After reset every read returns 0 and `sp_odd` is 0.
- R2: Word and address codes are 4..7 for data registers 0..3, 10 and 11 for address registers 0 and 1, 12 for the static base, 13 for the frame base, 14 for the stack pointer and 15 for the interrupt table base. A write stores `wr_data[15:0]` into a data register or `wr_data[23:0]` into a 24-bit register. A read returns the value zero-extended to 32 bits.
- R3: Byte codes are 0 for data register 0 low byte, 1 for its high byte, 2 for data register 1 low byte and 3 for its high byte. A byte write stores `wr_data[7:0]` into the addressed byte and leaves the other byte of the register unchanged. A byte read returns that byte in bits 7:0 with zeros above.
- R4: Code 8 is the pair {data register 2, data register 0}. Code 9 is the pair {data register 3, data register 1}. In each pair the first register is the upper half. A pair write updates both halves in the same cycle from `wr_data[31:16]` and `wr_data[15:0]`. A pair read returns the concatenation.
- R5: `bank_sel` = 0 selects bank 0 and 1 selects bank 1 for reads and writes of the data registers, address registers and frame base. The static base, stack pointers and interrupt table base are the same in both banks.
- R6: Code 14 reaches the user stack pointer when `stk_sel` = 0 and the interrupt stack pointer when `stk_sel` = 1. A write changes only the selected copy.
- R7: `sp_odd` is 1 exactly when bit 0 of the currently selected stack pointer is 1.
- R8: Codes 16 to 31 read as 0. A write with such a code changes no register.
- R9: A read of the register being written in the same cycle returns the old value. The new value is visible after the clock edge. The two read ports operate independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel | input | 1 | Register bank select |
| stk_sel | input | 1 | Stack pointer select: 0 user, 1 interrupt |
| rd_sel_a | input | 5 | Register code for read port A |
| rd_data_a | output | 32 | Zero-extended read data, port A |
| rd_sel_b | input | 5 | Register code for read port B |
| rd_data_b | output | 32 | Zero-extended read data, port B |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 5 | Register code for the write |
| wr_data | input | 32 | Write data, low-aligned to the operand size |
| sp_odd | output | 1 | Active stack pointer holds an odd address |

## Verification
A write and a read of the same register in one cycle is the collision that matters. A byte or pair write that overlaps a word read on the other port is a second case of it. The bench drives such collisions on purpose: it writes a register while port A reads the same code, and in randomised traffic it often reads a pair while one of its halves is written. Its behavioural model checks each read against the state before the edge and then applies the write, so a read that shows the new value one cycle early is flagged. Bank and stack selects change in the same cycles as writes, so misrouted copies show up on later reads.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int SEL_W = 5;

  typedef enum logic [SEL_W-1:0] {
    SEL_D0L  = 5'd0,
    SEL_D0H  = 5'd1,
    SEL_D1L  = 5'd2,
    SEL_D1H  = 5'd3,
    SEL_D0   = 5'd4,
    SEL_D1   = 5'd5,
    SEL_D2   = 5'd6,
    SEL_D3   = 5'd7,
    SEL_P20  = 5'd8,
    SEL_P31  = 5'd9,
    SEL_ADR0 = 5'd10,
    SEL_ADR1 = 5'd11,
    SEL_SBAS = 5'd12,
    SEL_FBAS = 5'd13,
    SEL_STK  = 5'd14,
    SEL_ITAB = 5'd15
  } rsel_e;
endpackage

// File: rtl/rf_bank.sv
module rf_bank
  import rf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 24,
  parameter int NUM_D  = 4,
  parameter int NUM_A  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [SEL_W-1:0]              sel,
  input  logic [2*DATA_W-1:0]           wdata,
  output logic [NUM_D-1:0][DATA_W-1:0]  dreg,
  output logic [NUM_A-1:0][ADDR_W-1:0]  areg,
  output logic [ADDR_W-1:0]             fbase
);
  localparam int HALF_W = DATA_W / 2;

  // Data registers: per-byte enables so byte, word and pair writes share one path
  for (genvar i = 0; i < NUM_D; i++) begin : g_data
    logic              lo_en, hi_en;
    logic [DATA_W-1:0] nv;
    logic [DATA_W-1:0] q;

    always_comb begin
      lo_en = 1'b0;
      hi_en = 1'b0;
      nv    = wdata[DATA_W-1:0];
      if (we) begin
        case (sel)
          SEL_D0L: if (i == 0) lo_en = 1'b1;
          SEL_D0H: if (i == 0) begin
            hi_en = 1'b1;
            nv    = {wdata[HALF_W-1:0], {HALF_W{1'b0}}};
          end
          SEL_D1L: if (i == 1) lo_en = 1'b1;
          SEL_D1H: if (i == 1) begin
            hi_en = 1'b1;
            nv    = {wdata[HALF_W-1:0], {HALF_W{1'b0}}};
          end
          SEL_D0:  if (i == 0) begin lo_en = 1'b1; hi_en = 1'b1; end
          SEL_D1:  if (i == 1) begin lo_en = 1'b1; hi_en = 1'b1; end
          SEL_D2:  if (i == 2) begin lo_en = 1'b1; hi_en = 1'b1; end
          SEL_D3:  if (i == 3) begin lo_en = 1'b1; hi_en = 1'b1; end
          SEL_P20: begin
            if (i == 0) begin lo_en = 1'b1; hi_en = 1'b1; end
            if (i == 2) begin
              lo_en = 1'b1; hi_en = 1'b1;
              nv    = wdata[2*DATA_W-1:DATA_W];
            end
          end
          SEL_P31: begin
            if (i == 1) begin lo_en = 1'b1; hi_en = 1'b1; end
            if (i == 3) begin
              lo_en = 1'b1; hi_en = 1'b1;
              nv    = wdata[2*DATA_W-1:DATA_W];
            end
          end
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else begin
        if (lo_en) q[HALF_W-1:0]      <= nv[HALF_W-1:0];
        if (hi_en) q[DATA_W-1:HALF_W] <= nv[DATA_W-1:HALF_W];
      end
    end

    assign dreg[i] = q;
  end

  // Address registers
  for (genvar j = 0; j < NUM_A; j++) begin : g_addr
    logic [ADDR_W-1:0] q;
    logic              en;
    assign en = we && (sel == SEL_W'(int'(SEL_ADR0) + j));

    always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (en) q <= wdata[ADDR_W-1:0];
    end

    assign areg[j] = q;
  end

  // Frame base
  logic [ADDR_W-1:0] fb_q;
  always_ff @(posedge clk) begin
    if (rst)                           fb_q <= '0;
    else if (we && sel == SEL_FBAS)    fb_q <= wdata[ADDR_W-1:0];
  end
  assign fbase = fb_q;

  // A low-byte write must keep the high byte
  assert_byte_keep_R3: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SEL_D0L) |=> dreg[0][DATA_W-1:HALF_W] == $past(dreg[0][DATA_W-1:HALF_W]));

  // A pair write lands both halves on the same edge
  assert_pair_both_R4: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SEL_P20) |=> (dreg[0] == $past(wdata[DATA_W-1:0]) &&
                                dreg[2] == $past(wdata[2*DATA_W-1:DATA_W])));

  // A bank that is not written keeps its contents
  assert_idle_bank_R5: assert property (@(posedge clk) disable iff (rst)
    !we |=> ($stable(dreg) && $stable(areg) && $stable(fbase)));
endmodule

// File: rtl/rf_shared.sv
module rf_shared
  import rf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 24,
  parameter int NUM_STK = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [SEL_W-1:0]     sel,
  input  logic [2*DATA_W-1:0]  wdata,
  input  logic                 stk_sel,
  output logic [ADDR_W-1:0]    sbase,
  output logic [ADDR_W-1:0]    itab,
  output logic [ADDR_W-1:0]    sp_act,
  output logic                 sp_odd
);
  logic [NUM_STK-1:0][ADDR_W-1:0] stk_q;

  for (genvar k = 0; k < NUM_STK; k++) begin : g_stk
    logic en;
    assign en = we && (sel == SEL_STK) && (stk_sel == k[0]);
    always_ff @(posedge clk) begin
      if (rst)     stk_q[k] <= '0;
      else if (en) stk_q[k] <= wdata[ADDR_W-1:0];
    end
  end

  logic [ADDR_W-1:0] sb_q, it_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      sb_q <= '0;
      it_q <= '0;
    end else if (we) begin
      if (sel == SEL_SBAS) sb_q <= wdata[ADDR_W-1:0];
      if (sel == SEL_ITAB) it_q <= wdata[ADDR_W-1:0];
    end
  end

  assign sbase  = sb_q;
  assign itab   = it_q;
  assign sp_act = stk_q[stk_sel];
  assign sp_odd = sp_act[0];

  // Only the selected stack pointer may change
  assert_user_stk_only_R6: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SEL_STK && !stk_sel) |=> $stable(stk_q[1]));
  assert_intr_stk_only_R6: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SEL_STK && stk_sel) |=> $stable(stk_q[0]));
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import rf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 24,
  parameter int NUM_D  = 4,
  parameter int NUM_A  = 2
) (
  input  logic [SEL_W-1:0]             sel,
  input  logic [NUM_D-1:0][DATA_W-1:0] dreg,
  input  logic [NUM_A-1:0][ADDR_W-1:0] areg,
  input  logic [ADDR_W-1:0]            fbase,
  input  logic [ADDR_W-1:0]            sbase,
  input  logic [ADDR_W-1:0]            sp_act,
  input  logic [ADDR_W-1:0]            itab,
  output logic [2*DATA_W-1:0]          rdata
);
  localparam int BUS_W  = 2 * DATA_W;
  localparam int HALF_W = DATA_W / 2;

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_D0L:  rdata = BUS_W'(dreg[0][HALF_W-1:0]);
      SEL_D0H:  rdata = BUS_W'(dreg[0][DATA_W-1:HALF_W]);
      SEL_D1L:  rdata = BUS_W'(dreg[1][HALF_W-1:0]);
      SEL_D1H:  rdata = BUS_W'(dreg[1][DATA_W-1:HALF_W]);
      SEL_D0:   rdata = BUS_W'(dreg[0]);
      SEL_D1:   rdata = BUS_W'(dreg[1]);
      SEL_D2:   rdata = BUS_W'(dreg[2]);
      SEL_D3:   rdata = BUS_W'(dreg[3]);
      SEL_P20:  rdata = {dreg[2], dreg[0]};
      SEL_P31:  rdata = {dreg[3], dreg[1]};
      SEL_ADR0: rdata = BUS_W'(areg[0]);
      SEL_ADR1: rdata = BUS_W'(areg[1]);
      SEL_SBAS: rdata = BUS_W'(sbase);
      SEL_FBAS: rdata = BUS_W'(fbase);
      SEL_STK:  rdata = BUS_W'(sp_act);
      SEL_ITAB: rdata = BUS_W'(itab);
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rf_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 24,
  parameter int NUM_BANKS = 2,
  parameter int NUM_RD    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bank_sel,
  input  logic                stk_sel,
  input  logic [SEL_W-1:0]    rd_sel_a,
  output logic [2*DATA_W-1:0] rd_data_a,
  input  logic [SEL_W-1:0]    rd_sel_b,
  output logic [2*DATA_W-1:0] rd_data_b,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    wr_sel,
  input  logic [2*DATA_W-1:0] wr_data,
  output logic                sp_odd
);
  localparam int NUM_D = 4;
  localparam int NUM_A = 2;
  localparam int BUS_W = 2 * DATA_W;

  logic [NUM_BANKS-1:0][NUM_D-1:0][DATA_W-1:0] bk_d;
  logic [NUM_BANKS-1:0][NUM_A-1:0][ADDR_W-1:0] bk_a;
  logic [NUM_BANKS-1:0][ADDR_W-1:0]            bk_fb;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bwe;
    assign bwe = wr_en && (bank_sel == b[0]);
    rf_bank #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_D(NUM_D), .NUM_A(NUM_A)
    ) u_bank (
      .clk  (clk),
      .rst  (rst),
      .we   (bwe),
      .sel  (wr_sel),
      .wdata(wr_data),
      .dreg (bk_d[b]),
      .areg (bk_a[b]),
      .fbase(bk_fb[b])
    );
  end

  logic [ADDR_W-1:0] sbase, itab, sp_act;

  rf_shared #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_STK(2)) u_shared (
    .clk    (clk),
    .rst    (rst),
    .we     (wr_en),
    .sel    (wr_sel),
    .wdata  (wr_data),
    .stk_sel(stk_sel),
    .sbase  (sbase),
    .itab   (itab),
    .sp_act (sp_act),
    .sp_odd (sp_odd)
  );

  logic [NUM_RD-1:0][SEL_W-1:0] rsel;
  logic [NUM_RD-1:0][BUS_W-1:0] rdat;
  assign rsel[0] = rd_sel_a;
  assign rsel[1] = rd_sel_b;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    rf_read_port #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_D(NUM_D), .NUM_A(NUM_A)
    ) u_rd (
      .sel   (rsel[p]),
      .dreg  (bk_d[bank_sel]),
      .areg  (bk_a[bank_sel]),
      .fbase (bk_fb[bank_sel]),
      .sbase (sbase),
      .sp_act(sp_act),
      .itab  (itab),
      .rdata (rdat[p])
    );
  end

  assign rd_data_a = rdat[0];
  assign rd_data_b = rdat[1];

  // A write with an unused code touches no register of the visible bank
  assert_bad_code_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel >= SEL_W'(16)) |=> ($stable(bk_d) && $stable(bk_a) && $stable(sbase)));
endmodule

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;
  logic        clk = 1'b0;
  logic        rst, bank_sel, stk_sel, wr_en;
  logic [4:0]  rd_sel_a, rd_sel_b, wr_sel;
  logic [31:0] wr_data, rd_data_a, rd_data_b;
  logic        sp_odd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  banked_regfile u_banked_regfile (
    .clk(clk), .rst(rst), .bank_sel(bank_sel), .stk_sel(stk_sel),
    .rd_sel_a(rd_sel_a), .rd_data_a(rd_data_a),
    .rd_sel_b(rd_sel_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .sp_odd(sp_odd)
  );

  // Behavioural model state
  logic [15:0] m_d  [2][4];
  logic [23:0] m_a  [2][2];
  logic [23:0] m_fb [2];
  logic [23:0] m_sp [2];
  logic [23:0] m_sb, m_it;

  function automatic logic [31:0] mread(logic [4:0] s, bit b, bit k);
    case (s)
      0: return {24'h0, m_d[b][0][7:0]};
      1: return {24'h0, m_d[b][0][15:8]};
      2: return {24'h0, m_d[b][1][7:0]};
      3: return {24'h0, m_d[b][1][15:8]};
      4, 5, 6, 7: return {16'h0, m_d[b][s-4]};
      8: return {m_d[b][2], m_d[b][0]};
      9: return {m_d[b][3], m_d[b][1]};
      10: return {8'h0, m_a[b][0]};
      11: return {8'h0, m_a[b][1]};
      12: return {8'h0, m_sb};
      13: return {8'h0, m_fb[b]};
      14: return {8'h0, m_sp[k]};
      15: return {8'h0, m_it};
      default: return 32'h0;
    endcase
  endfunction

  task automatic mclear();
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < 4; i++) m_d[b][i] = 16'h0;
      m_a[b][0] = 24'h0; m_a[b][1] = 24'h0; m_fb[b] = 24'h0;
      m_sp[b] = 24'h0;
    end
    m_sb = 24'h0; m_it = 24'h0;
  endtask

  task automatic mwrite(logic [4:0] s, logic [31:0] d, bit b, bit k);
    case (s)
      0: m_d[b][0][7:0]  = d[7:0];
      1: m_d[b][0][15:8] = d[7:0];
      2: m_d[b][1][7:0]  = d[7:0];
      3: m_d[b][1][15:8] = d[7:0];
      4, 5, 6, 7: m_d[b][s-4] = d[15:0];
      8: begin m_d[b][0] = d[15:0]; m_d[b][2] = d[31:16]; end
      9: begin m_d[b][1] = d[15:0]; m_d[b][3] = d[31:16]; end
      10: m_a[b][0] = d[23:0];
      11: m_a[b][1] = d[23:0];
      12: m_sb = d[23:0];
      13: m_fb[b] = d[23:0];
      14: m_sp[k] = d[23:0];
      15: m_it = d[23:0];
      default: ;
    endcase
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, compare against model state before the
  // rising edge (old value on collision), then apply the write to the model.
  task automatic step(bit r, bit b, bit k, logic [4:0] ra, logic [4:0] rb,
                      bit we, logic [4:0] ws, logic [31:0] wd, string tag);
    @(negedge clk);
    rst = r; bank_sel = b; stk_sel = k; rd_sel_a = ra; rd_sel_b = rb;
    wr_en = we; wr_sel = ws; wr_data = wd;
    #1;
    if (!r) begin
      chk(tag, "rd_data_a", rd_data_a, mread(ra, b, k));
      chk(tag, "rd_data_b", rd_data_b, mread(rb, b, k));
      chk("R7", "sp_odd", {31'h0, sp_odd}, {31'h0, m_sp[k][0]});
    end
    @(posedge clk);
    if (r) mclear();
    else if (we) mwrite(ws, wd, b, k);
  endtask

  task automatic wr(bit b, bit k, logic [4:0] ws, logic [31:0] wd, string tag);
    step(0, b, k, ws, 5'd31, 1'b1, ws, wd, tag);
  endtask

  task automatic rd(bit b, bit k, logic [4:0] ra, logic [4:0] rb, string tag);
    step(0, b, k, ra, rb, 1'b0, 5'd0, 32'h0, tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    mclear();
    // Dirty the registers first so reset has work to do
    step(1, 0, 0, 0, 0, 0, 0, 0, "R1");
    wr(0, 0, 5'd8, 32'hDEAD_BEEF, "R4");
    wr(1, 1, 5'd14, 32'h00_1235, "R6");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R1");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R1");
    // R1: all codes read zero in both banks and both stacks
    for (int c = 0; c < 32; c += 2) begin
      rd(0, 0, 5'(c), 5'(c + 1), "R1");
      rd(1, 1, 5'(c), 5'(c + 1), "R1");
    end

    // R2: word and 24-bit writes, upper write-data bits ignored
    wr(0, 0, 5'd4, 32'hFFFF_1111, "R2");
    wr(0, 0, 5'd5, 32'h0000_2222, "R2");
    wr(0, 0, 5'd6, 32'h0000_3333, "R2");
    wr(0, 0, 5'd7, 32'h0000_4444, "R2");
    wr(0, 0, 5'd10, 32'hFFAB_CDEF, "R2");
    wr(0, 0, 5'd11, 32'h0012_3456, "R2");
    wr(0, 0, 5'd12, 32'h0065_4321, "R2");
    wr(0, 0, 5'd13, 32'h00F0_0F0F, "R2");
    wr(0, 0, 5'd15, 32'h00C0_FFEE, "R2");
    for (int c = 4; c < 16; c += 2) rd(0, 0, 5'(c), 5'(c + 1), "R2");

    // R3: byte writes keep the neighbour byte
    wr(0, 0, 5'd0, 32'hFFFF_FFAA, "R3");
    wr(0, 0, 5'd1, 32'h0000_00BB, "R3");
    wr(0, 0, 5'd3, 32'h0000_00CC, "R3");
    wr(0, 0, 5'd2, 32'h0000_00DD, "R3");
    rd(0, 0, 5'd0, 5'd1, "R3");
    rd(0, 0, 5'd2, 5'd3, "R3");
    rd(0, 0, 5'd4, 5'd5, "R3");

    // R4: pair writes and reads
    wr(0, 0, 5'd8, 32'h1357_2468, "R4");
    wr(0, 0, 5'd9, 32'h9ABC_DEF0, "R4");
    rd(0, 0, 5'd8, 5'd9, "R4");
    rd(0, 0, 5'd4, 5'd6, "R4");
    rd(0, 0, 5'd5, 5'd7, "R4");

    // R5: bank 1 is separate, shared registers are common
    wr(1, 0, 5'd4, 32'h0000_AAAA, "R5");
    wr(1, 0, 5'd10, 32'h0011_1111, "R5");
    wr(1, 0, 5'd13, 32'h0022_2222, "R5");
    wr(1, 0, 5'd12, 32'h0033_3333, "R5");
    rd(0, 0, 5'd4, 5'd10, "R5");
    rd(0, 0, 5'd13, 5'd12, "R5");
    rd(1, 0, 5'd4, 5'd10, "R5");
    rd(1, 0, 5'd13, 5'd15, "R5");

    // R6 / R7: stack pointer copies and odd flag
    wr(0, 0, 5'd14, 32'h0000_1001, "R6");
    wr(0, 1, 5'd14, 32'h0000_2000, "R6");
    rd(0, 0, 5'd14, 5'd14, "R6");
    rd(0, 1, 5'd14, 5'd14, "R7");
    wr(1, 1, 5'd14, 32'h0000_2003, "R7");
    rd(1, 1, 5'd14, 5'd12, "R7");
    rd(1, 0, 5'd14, 5'd12, "R6");

    // R8: unused codes read zero, writes change nothing
    for (int c = 16; c < 32; c++) wr(c[0], c[1], 5'(c), 32'hFFFF_FFFF, "R8");
    for (int c = 0; c < 32; c += 2) begin
      rd(0, 0, 5'(c), 5'(c + 1), "R8");
      rd(1, 1, 5'(c), 5'(c + 1), "R8");
    end

    // R9: same-cycle read of the written register shows the old value
    step(0, 0, 0, 5'd4, 5'd8, 1'b1, 5'd4, 32'h0000_5A5A, "R9");
    step(0, 0, 0, 5'd4, 5'd0, 1'b1, 5'd0, 32'h0000_0077, "R9");
    step(0, 0, 0, 5'd8, 5'd4, 1'b1, 5'd8, 32'h0102_0304, "R9");
    rd(0, 0, 5'd8, 5'd0, "R9");

    // R9: random traffic with collisions across both ports
    for (int n = 0; n < 600; n++) begin
      logic [4:0] ws, ra, rb;
      ws = 5'($urandom_range(0, 17));
      ra = (n % 3 == 0) ? ws : 5'($urandom_range(0, 20));
      rb = 5'($urandom_range(0, 20));
      step(0, 1'($urandom), 1'($urandom), ra, rb, 1'($urandom), ws, $urandom, "R9");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule